// File: doc/BRIEF.md
# I2C Bit-Rate Control Register

This block holds the clock configuration of an I2C master and generates its bit-rate timing. A single 16-bit control word carries three fields: an input spike-filter switch, an interface enable, and a 5-bit prescaler code. While the interface is enabled and a nonzero code is selected, the block divides the system clock by the divisor that the code selects and emits a one-cycle bit-rate tick once per period. Turning the filter on lengthens the period by one clock.

The block also cleans the incoming SDA and SCL levels. With the filter on, a new level reaches the filtered output only after it has been stable for two consecutive system clocks, so that single short spikes are removed. With the filter off, the raw levels pass straight through. Disabling the interface, either by a software write or by a bus error reported by the protocol engine, produces a one-cycle clear strobe. Neighbouring status and control logic uses this strobe to reset itself, keeping only the bus-error flag and its interrupt enable. The same strobe stops any transfer at once and lets both lines go.

The prescaler field is protected: it can only be changed while the interface is off, or by the same write that turns the interface off.

Top module: `i2cRateGen`

## Requirements
- R1: After reset the register reads 0x0000. Bit 15 and bits 7..0 always read 0.
- R2: A write with bit 13 = 1 sets the interface enable, and a write with bit 13 = 0 clears it. The new value is visible from the cycle after the write edge.
- R3: A `busErr` pulse clears the enable on the next edge, and it wins over a software write that sets bit 13 in the same cycle.
- R4: The prescaler code in bits 12..8 takes the written value only if the enable is 0 before the write, or if the write itself has bit 13 = 0. Otherwise the old code is kept.
- R5: The divisor is 12*code+16 for codes 1 to 30 (code 1 = 28, code 4 = 64) and 400 for code 31. `bitTick` is high for exactly one cycle in every divisor cycles.
- R6: With bit 14 = 1 the divisor is one larger than the value given in R5.
- R7: No tick is produced while the enable is 0 or while the code is 0.
- R8: The divide counter restarts whenever the enable rises or the divisor changes. The first tick is then high in clock cycle number divisor, counting the cycle just after the write edge as cycle 1.
- R9: With the filter on, a new SDA or SCL level appears on the filtered output in the third cycle after the input changes, and a pulse that spans only one sampling edge never appears. With the filter off, the filtered outputs follow the inputs directly.
- R10: `sibClear` is high for one cycle, in the cycle whose edge turns the enable from 1 to 0 (by software or by a bus error). It stays low when the enable is already 0.
- R11: Bit 14 can be written at any time, including while the interface is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read value |
| busErr | input | 1 | Bus-error pulse from the protocol engine |
| sdaIn | input | 1 | Raw SDA level |
| sclIn | input | 1 | Raw SCL level |
| sdaFilt | output | 1 | Filtered SDA level |
| sclFilt | output | 1 | Filtered SCL level |
| bitTick | output | 1 | One-cycle bit-rate tick |
| ifEnable | output | 1 | Current interface enable |
| sibClear | output | 1 | Clear strobe for sibling status/control bits |

## Verification
A corrupted prescaler code or filter bit shows up immediately in `rdData` and, within one period, as a wrong tick spacing. Measuring both the first-tick latency and the following interval therefore separates a wrong divisor from a missed counter restart. A stale enable appears as missing or extra ticks, or as a missing `sibClear` in the cycle of the write or bus error. A faulty filter stage shows up as a wrong output latency (the level arrives one cycle early or late) or as a single-edge spike leaking through to `sdaFilt`/`sclFilt`.

// File: rtl/i2cRatePkg.sv
package i2cRatePkg;

  localparam int CODE_W    = 5;
  localparam int REG_W     = 16;
  localparam int DIV_W     = 9;
  localparam int DIV_STEP  = 12;
  localparam int DIV_BASE  = 16;
  localparam int DIV_TOP   = 400;
  localparam int FILT_BIT  = 14;
  localparam int EN_BIT    = 13;
  localparam int CODE_LSB  = 8;
  localparam int NUM_LINES = 2;

  typedef struct packed {
    logic              en;
    logic              filtOn;
    logic [CODE_W-1:0] code;
  } rateCfg_t;

  typedef struct packed {
    logic reload;
    logic sibClear;
  } ctrlStrobe_t;

  // Divisor for a prescaler code; zero means "no ticks"
  function automatic logic [DIV_W-1:0] divisorOf(input logic [CODE_W-1:0] code,
                                                 input logic filtOn);
    int base;
    if (code == '0) begin
      base = 0;
    end else if (code == {CODE_W{1'b1}}) begin
      base = DIV_TOP;
    end else begin
      base = DIV_STEP * int'(code) + DIV_BASE;
    end
    if (base != 0 && filtOn) base = base + 1;
    return DIV_W'(base);
  endfunction

endpackage

// File: rtl/i2cRateCtrl.sv
module i2cRateCtrl
  import i2cRatePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             busErr,
  output rateCfg_t         cfg,
  output ctrlStrobe_t      strobe,
  output logic [REG_W-1:0] rdData
);

  rateCfg_t cfgQ, cfgNext;
  logic     codeWrOk;
  logic     unusedWrBits;

  assign unusedWrBits = ^{wrData[REG_W-1], wrData[CODE_LSB-1:0]};

  always_comb begin
    cfgNext  = cfgQ;
    codeWrOk = wrEn && (!cfgQ.en || !wrData[EN_BIT]);
    if (wrEn) begin
      cfgNext.filtOn = wrData[FILT_BIT];
      cfgNext.en     = wrData[EN_BIT];
    end
    if (codeWrOk) cfgNext.code = wrData[CODE_LSB +: CODE_W];
    if (busErr) cfgNext.en = 1'b0;
  end

  always_comb begin
    strobe.sibClear = cfgQ.en && !cfgNext.en;
    strobe.reload   = (cfgNext.en && !cfgQ.en) ||
                      (divisorOf(cfgNext.code, cfgNext.filtOn) !=
                       divisorOf(cfgQ.code, cfgQ.filtOn));
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgNext;
  end

  assign cfg = cfgQ;

  always_comb begin
    rdData                        = '0;
    rdData[FILT_BIT]              = cfgQ.filtOn;
    rdData[EN_BIT]                = cfgQ.en;
    rdData[CODE_LSB +: CODE_W]    = cfgQ.code;
  end

endmodule

// File: rtl/i2cRateDatapath.sv
module i2cRateDatapath
  import i2cRatePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  rateCfg_t             cfg,
  input  ctrlStrobe_t          strobe,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [NUM_LINES-1:0] lineFilt,
  output logic                 tick
);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] cnt;
  logic             unusedStrobe;

  assign unusedStrobe = strobe.sibClear;
  assign divisor      = divisorOf(cfg.code, cfg.filtOn);
  assign tick         = cfg.en && (divisor != '0) && (cnt == divisor - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)                           cnt <= '0;
    else if (strobe.reload || !cfg.en || tick) cnt <= '0;
    else if (divisor != '0)              cnt <= cnt + 1'b1;
  end

  // One agreement filter per bus line
  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    logic samp0, samp1, held;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        samp0 <= 1'b1;
        samp1 <= 1'b1;
        held  <= 1'b1;
      end else begin
        samp0 <= lineIn[i];
        samp1 <= samp0;
        if (samp0 == samp1) held <= samp0;
      end
    end
    assign lineFilt[i] = cfg.filtOn ? held : lineIn[i];
  end

endmodule

// File: rtl/i2cRateGen.sv
module i2cRateGen
  import i2cRatePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        busErr,
  input  logic        sdaIn,
  input  logic        sclIn,
  output logic        sdaFilt,
  output logic        sclFilt,
  output logic        bitTick,
  output logic        ifEnable,
  output logic        sibClear
);

  rateCfg_t             cfg;
  ctrlStrobe_t          strobe;
  logic [NUM_LINES-1:0] lineFilt;

  i2cRateCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .busErr (busErr),
    .cfg    (cfg),
    .strobe (strobe),
    .rdData (rdData)
  );

  i2cRateDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .strobe   (strobe),
    .lineIn   ({sclIn, sdaIn}),
    .lineFilt (lineFilt),
    .tick     (bitTick)
  );

  assign sdaFilt  = lineFilt[0];
  assign sclFilt  = lineFilt[1];
  assign ifEnable = cfg.en;
  assign sibClear = strobe.sibClear;

endmodule

// File: rtl/i2cRateCheck.sv
module i2cRateCheck (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        busErr,
  input logic        bitTick,
  input logic        ifEnable,
  input logic        sibClear
);

  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15] == 1'b0) && (rdData[7:0] == 8'h00));

  assert_sw_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[13] && !busErr) |=> ifEnable);

  assert_sw_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[13]) |=> !ifEnable);

  assert_hw_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !ifEnable);

  assert_code_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ifEnable && wrEn && wrData[13]) |=> $stable(rdData[12:8]));

  assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  assert_no_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ifEnable || rdData[12:8] == 5'd0) |-> !bitTick);

  assert_sib_needs_en_R10: assert property (@(posedge clk) disable iff (!rstN)
    sibClear |-> ifEnable);

  assert_sib_then_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    sibClear |=> !ifEnable);

endmodule

bind i2cRateGen i2cRateCheck u_check (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .busErr   (busErr),
  .bitTick  (bitTick),
  .ifEnable (ifEnable),
  .sibClear (sibClear)
);

// File: tb/i2cRateGen_bench.sv
module i2cRateGen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        busErr = 1'b0;
  logic        sdaIn = 1'b1;
  logic        sclIn = 1'b1;
  logic        sdaFilt, sclFilt, bitTick, ifEnable, sibClear;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;
  logic sibSeen;

  always #2 clk = ~clk;

  i2cRateGen u_i2cRateGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .busErr(busErr), .sdaIn(sdaIn), .sclIn(sclIn), .sdaFilt(sdaFilt),
    .sclFilt(sclFilt), .bitTick(bitTick), .ifEnable(ifEnable), .sibClear(sibClear)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failCount = failCount + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  function automatic logic [15:0] word(input bit filt, input bit en, input int code);
    return {1'b0, filt, en, 5'(code), 8'h00};
  endfunction

  function automatic int expDiv(input int code, input bit filt);
    int d = (code == 31) ? 400 : 12 * code + 16;
    return d + (filt ? 1 : 0);
  endfunction

  // Write one word; sibClear sampled during the write cycle
  task automatic regWrite(input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    #1 sibSeen = sibClear;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  // Called in cycle 1 after a restarting write; checks first tick and period
  task automatic measureTicks(input int div, input string tag);
    int k = 1;
    int p = 0;
    while (!bitTick && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check(k == div, {tag, " first tick"}, k, div);
    @(negedge clk);
    p = 1;
    while (!bitTick && p < 1000) begin
      @(negedge clk);
      p++;
    end
    check(p == div, {tag, " period"}, p, div);
  endtask

  task automatic testReset();
    check(rdData == 16'h0000, "R1 reset value", rdData, 0);
    check(ifEnable == 1'b0 && bitTick == 1'b0, "R1 reset outputs", {ifEnable, bitTick}, 0);
  endtask

  task automatic testDivisors();
    regWrite(word(0, 1, 1));
    check(ifEnable == 1'b1, "R2 enable set", ifEnable, 1);
    check(rdData == 16'h2100, "R1 R2 readback", rdData, 16'h2100);
    measureTicks(28, "R5 R8 code1");
    regWrite(word(0, 0, 4));
    check(ifEnable == 1'b0, "R2 enable clear", ifEnable, 0);
    regWrite(word(0, 1, 4));
    measureTicks(64, "R5 code4");
    regWrite(word(0, 0, 17));
    regWrite(word(0, 1, 17));
    measureTicks(expDiv(17, 0), "R5 code17");
    regWrite(word(0, 0, 31));
    regWrite(word(0, 1, 31));
    measureTicks(400, "R5 code31");
  endtask

  task automatic testFilterDivisor();
    regWrite(word(0, 0, 2));
    regWrite(word(0, 1, 2));
    repeat (13) @(negedge clk);
    regWrite(word(1, 1, 2));
    check(rdData[14] == 1'b1, "R11 filter bit written while enabled", rdData[14], 1);
    measureTicks(41, "R6 R8 filter restart");
  endtask

  task automatic testLock();
    regWrite(word(0, 1, 9));
    check(rdData[12:8] == 5'd2, "R4 code locked", rdData[12:8], 2);
    check(sibSeen == 1'b0, "R10 no strobe on stay-enabled", sibSeen, 0);
    regWrite(word(0, 0, 9));
    check(rdData[12:8] == 5'd9, "R4 code written with disable", rdData[12:8], 9);
    check(sibSeen == 1'b1, "R10 strobe on software clear", sibSeen, 1);
    regWrite(word(0, 0, 3));
    check(sibSeen == 1'b0, "R10 no strobe when already off", sibSeen, 0);
    check(rdData[12:8] == 5'd3, "R4 code written while off", rdData[12:8], 3);
  endtask

  task automatic testBusErr();
    regWrite(word(0, 1, 3));
    repeat (5) @(negedge clk);
    @(negedge clk);
    busErr = 1'b1;
    wrEn = 1'b1;
    wrData = word(0, 1, 3);
    #1 sibSeen = sibClear;
    @(negedge clk);
    busErr = 1'b0;
    wrEn = 1'b0;
    check(ifEnable == 1'b0, "R3 bus error beats software set", ifEnable, 0);
    check(sibSeen == 1'b1, "R10 strobe on bus error", sibSeen, 1);
    @(negedge clk);
    busErr = 1'b1;
    #1 sibSeen = sibClear;
    @(negedge clk);
    busErr = 1'b0;
    check(sibSeen == 1'b0, "R10 no strobe on bus error while off", sibSeen, 0);
  endtask

  task automatic testNoTick();
    int seen = 0;
    regWrite(word(0, 1, 0));
    repeat (300) begin
      @(negedge clk);
      if (bitTick) seen++;
    end
    check(seen == 0, "R7 code 0 no ticks", seen, 0);
    regWrite(word(0, 0, 1));
    repeat (100) begin
      @(negedge clk);
      if (bitTick) seen++;
    end
    check(seen == 0, "R7 disabled no ticks", seen, 0);
  endtask

  task automatic testLineFilter();
    int leak = 0;
    regWrite(word(1, 0, 1));
    @(negedge clk);
    sdaIn = 1'b0;
    @(negedge clk);
    check(sdaFilt == 1'b1, "R9 sda still old after 1", sdaFilt, 1);
    @(negedge clk);
    check(sdaFilt == 1'b1, "R9 sda still old after 2", sdaFilt, 1);
    @(negedge clk);
    check(sdaFilt == 1'b0, "R9 sda new after 3", sdaFilt, 0);
    sdaIn = 1'b1;
    repeat (4) @(negedge clk);
    sclIn = 1'b0;
    @(negedge clk);
    sclIn = 1'b1;
    repeat (4) begin
      if (sclFilt != 1'b1) leak++;
      @(negedge clk);
    end
    check(leak == 0, "R9 scl glitch suppressed", leak, 0);
    regWrite(word(0, 0, 1));
    sdaIn = 1'b0;
    #1 check(sdaFilt == 1'b0, "R9 pass-through sda", sdaFilt, 0);
    sclIn = 1'b0;
    #1 check(sclFilt == 1'b0, "R9 pass-through scl", sclFilt, 0);
    sdaIn = 1'b1;
    sclIn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDivisors();
    testFilterDivisor();
    testLock();
    testBusErr();
    testNoTick();
    testLineFilter();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule